// File: doc/BRIEF.md
# Device-Side Two-Wire Serial Byte Sender

This block sends one byte from a peripheral to a host over a two-wire, open-drain clock/data link. It produces the link clock itself, the way a keyboard does. The block never drives a line high. To put a 0 on a line it enables that line's pull-down. To put a 1 on a line it releases it and lets the external pull-up raise it. The block samples the levels of both lines, so it can tell when the host is holding the bus.

A send starts with a one-cycle strobe that carries the byte. The block first waits for both lines to stay high for a qualifying idle interval. It then shifts out an 11-bit frame. For each bit, the block sets the data line and then pulses the clock low for half a bit period. If the host pulls the clock low between pulses, the frame is abandoned. In every case, a one-cycle completion pulse marks the end of the attempt, and an error flag shows whether the attempt failed. All timing comes from the system clock rate in kHz and the interval lengths in microseconds, given as parameters.

Top module: `twowire_dev_tx`

## Requirements
- R1: After reset, both pull enables are off and the done and error outputs are 0. Whenever the block is idle, the clock pull is off.
- R2: A start strobe sampled while idle opens an idle-qualification window of IDLE_CYC cycles. The data pull for the start bit is set at the end of that window. The first clock pull begins IDLE_CYC+1 cycles after the cycle in which the strobe was sampled.
- R3: If either line reads low at any point in the qualification window, the attempt ends: done pulses with error 1, and no clock pulse is produced.
- R4: A completed frame has exactly 11 clock pulses. On each pulse, the data line carries one bit, in this order: bit 0 is the start bit (0); bits 1 to 8 are the byte, least significant bit first; bit 9 is parity; bit 10 is the stop bit (1).
- R5: The parity bit is 1 exactly when the byte holds an even number of ones, which makes the total count of ones odd.
- R6: Each data value is set one cycle before its clock pull begins and stays unchanged while the clock is pulled. Each clock pull lasts exactly HALF_CYC cycles. It is followed by a released phase of HALF_CYC cycles.
- R7: The clock line is checked at the end of the released phase of bits 0 to 9. If it reads low there, the frame is abandoned: the data pull is released, error is set to 1, done pulses, and no further clock pulse follows.
- R8: The clock line is not checked after the stop bit. A host that holds the clock low after the eleventh pulse does not cause an error.
- R9: Done is a single-cycle pulse for both completion and abandonment. Error is 0 after a completed frame and 1 after an abandoned one. Error is cleared in the cycle after a new start strobe is accepted.
- R10: A start strobe that arrives while an attempt is in progress is ignored. The frame in flight carries the original byte and ends with a single done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_byte | input | 8 | Byte to send, captured with the start strobe |
| tx_go | input | 1 | One-cycle start strobe |
| clk_in | input | 1 | Sampled level of the bus clock line |
| dat_in | input | 1 | Sampled level of the bus data line |
| clk_pull | output | 1 | Pull-down enable for the bus clock line (1 = drive low) |
| dat_pull | output | 1 | Pull-down enable for the bus data line (1 = drive low) |
| done | output | 1 | One-cycle pulse at the end of every attempt |
| err | output | 1 | 1 when the last attempt was abandoned |

## Verification
The bench builds the block with CLK_KHZ=1000, IDLE_US=8 and HALF_US=3. This gives an 8-cycle idle window and 3-cycle half-bit phases, so one frame takes under 100 cycles. With frames that short, the bench can send every byte pattern in its table, then abandon frames at early, middle, parity and stop-bit positions, and still finish quickly. The exact strobe-to-first-pulse distance and the pulse widths become small numbers that can be compared directly.

// File: rtl/twtx_pkg.sv
package twtx_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 3;
    localparam int IDX_W      = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_QUAL,
        ST_SETUP,
        ST_LOW,
        ST_HIGH
    } twtx_state_e;

    typedef logic [FRAME_BITS-1:0] twtx_frame_t;

    // Parity bit that makes the count of ones across byte + parity odd.
    function automatic logic odd_fill(input logic [DATA_W-1:0] d);
        return ~(^d);
    endfunction

    // Number of system cycles in an interval, never less than one.
    function automatic int span_cycles(input int khz, input int us);
        int c;
        c = (khz * us) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/twtx_framer.sv
module twtx_framer
    import twtx_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output twtx_frame_t       frame
);
    assign frame[0] = 1'b0;

    for (genvar i = 0; i < DATA_W; i++) begin : g_payload
        assign frame[i+1] = data[i];
    end

    assign frame[DATA_W+1] = odd_fill(data);
    assign frame[DATA_W+2] = 1'b1;
endmodule

// File: rtl/twtx_timer.sv
module twtx_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] last,
    output logic         hit
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end

    assign hit = (cnt == last);
endmodule

// File: rtl/twowire_dev_tx.sv
module twowire_dev_tx
    import twtx_pkg::*;
#(
    parameter int CLK_KHZ = 50000,
    parameter int IDLE_US = 75,
    parameter int HALF_US = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_go,
    input  logic              clk_in,
    input  logic              dat_in,
    output logic              clk_pull,
    output logic              dat_pull,
    output logic              done,
    output logic              err
);
    localparam int IDLE_CYC = span_cycles(CLK_KHZ, IDLE_US);
    localparam int HALF_CYC = span_cycles(CLK_KHZ, HALF_US);
    localparam int MAX_CYC  = (IDLE_CYC > HALF_CYC) ? IDLE_CYC : HALF_CYC;
    localparam int TW       = $clog2(MAX_CYC) + 1;

    twtx_state_e      state;
    twtx_frame_t      frame_q, frame_new;
    logic [IDX_W-1:0] bit_idx;
    logic [TW-1:0]    tmr_last;
    logic             tmr_hit, tmr_clr;
    logic             bus_idle, last_bit, busy;

    assign bus_idle = clk_in & dat_in;
    assign last_bit = (bit_idx == IDX_W'(FRAME_BITS - 1));
    assign busy     = (state != ST_IDLE);
    assign tmr_last = (state == ST_QUAL) ? TW'(IDLE_CYC - 1) : TW'(HALF_CYC - 1);
    assign tmr_clr  = (state == ST_IDLE) || (state == ST_SETUP) || tmr_hit ||
                      ((state == ST_QUAL) && !bus_idle);

    twtx_framer u_framer (
        .data  (tx_byte),
        .frame (frame_new)
    );

    twtx_timer #(.W(TW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .clr  (tmr_clr),
        .last (tmr_last),
        .hit  (tmr_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            frame_q  <= '0;
            bit_idx  <= '0;
            clk_pull <= 1'b0;
            dat_pull <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (tx_go) begin
                        err     <= 1'b0;
                        frame_q <= frame_new;
                        bit_idx <= '0;
                        state   <= ST_QUAL;
                    end
                end
                ST_QUAL: begin
                    if (!bus_idle) begin
                        err      <= 1'b1;
                        done     <= 1'b1;
                        dat_pull <= 1'b0;
                        state    <= ST_IDLE;
                    end else if (tmr_hit) begin
                        dat_pull <= ~frame_q[0];
                        state    <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    clk_pull <= 1'b1;
                    state    <= ST_LOW;
                end
                ST_LOW: begin
                    if (tmr_hit) begin
                        clk_pull <= 1'b0;
                        state    <= ST_HIGH;
                    end
                end
                ST_HIGH: begin
                    if (tmr_hit) begin
                        if (last_bit) begin
                            dat_pull <= 1'b0;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else if (!clk_in) begin
                            dat_pull <= 1'b0;
                            err      <= 1'b1;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end else begin
                            bit_idx  <= bit_idx + 1'b1;
                            frame_q  <= frame_q >> 1;
                            dat_pull <= ~frame_q[1];
                            state    <= ST_SETUP;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/twtx_checks.sv
module twtx_checks #(
    parameter int HALF_CYC = 1
) (
    input logic clk,
    input logic rst,
    input logic tx_go,
    input logic busy,
    input logic clk_pull,
    input logic dat_pull,
    input logic done,
    input logic err
);
    int run;

    always_ff @(posedge clk) begin
        if (rst)           run <= 0;
        else if (clk_pull) run <= run + 1;
        else               run <= 0;
    end

    // R1: clock line released whenever no attempt is in flight
    a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !clk_pull);

    // R6: data held steady while the clock is pulled
    a_r6_data_steady_low: assert property (@(posedge clk) disable iff (rst)
        (clk_pull && $past(clk_pull)) |-> $stable(dat_pull));

    // R6: a pull never runs past half a bit
    a_r6_low_bounded: assert property (@(posedge clk) disable iff (rst)
        clk_pull |-> (run < HALF_CYC));

    // R6: a pull always lasts the full half bit
    a_r6_low_full: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_pull) |-> ($past(run) == HALF_CYC - 1));

    // R7: an abandoned attempt leaves both lines released
    a_r7_abort_releases: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> (!dat_pull && !clk_pull));

    // R9: done lasts a single cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: error cleared when a new send is accepted
    a_r9_err_cleared: assert property (@(posedge clk) disable iff (rst)
        (tx_go && !busy) |=> !err);
endmodule

bind twowire_dev_tx twtx_checks #(.HALF_CYC(HALF_CYC)) u_twtx_checks (
    .clk      (clk),
    .rst      (rst),
    .tx_go    (tx_go),
    .busy     (busy),
    .clk_pull (clk_pull),
    .dat_pull (dat_pull),
    .done     (done),
    .err      (err)
);

// File: tb/test_twowire_dev_tx.sv
module test_twowire_dev_tx;
    localparam int IDLE_CYC = 8;
    localparam int HALF_CYC = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_go = 1'b0;
    logic       host_clk = 1'b0;
    logic       host_dat = 1'b0;
    logic       clk_pull, dat_pull, done, err;
    logic       clk_line, dat_line;

    assign clk_line = ~(clk_pull | host_clk);
    assign dat_line = ~(dat_pull | host_dat);

    always #4 clk = ~clk;

    twowire_dev_tx #(.CLK_KHZ(1000), .IDLE_US(IDLE_CYC), .HALF_US(HALF_CYC)) i_twowire_dev_tx (
        .clk      (clk),
        .rst      (rst),
        .tx_byte  (tx_byte),
        .tx_go    (tx_go),
        .clk_in   (clk_line),
        .dat_in   (dat_line),
        .clk_pull (clk_pull),
        .dat_pull (dat_pull),
        .done     (done),
        .err      (err)
    );

    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    // Monitor: samples shortly after each rising edge
    int   cyc = 0, go_cyc = 0, first_cyc = 0, npulse = 0, run = 0, n_done = 0;
    bit   mon_busy = 1'b0, lowbad = 1'b0, prev_pull = 1'b0;
    logic bits [11];

    always @(posedge clk) begin
        #2;
        cyc++;
        if (tx_go && !mon_busy) begin
            mon_busy = 1'b1; npulse = 0; go_cyc = cyc; lowbad = 1'b0; n_done = 0;
        end
        if (clk_pull && !prev_pull) begin
            if (npulse == 0) first_cyc = cyc;
            if (npulse < 11) bits[npulse] = dat_line;
            npulse++;
        end
        if (clk_pull) run++;
        else begin
            if (run != 0 && run != HALF_CYC) lowbad = 1'b1;
            run = 0;
        end
        prev_pull = clk_pull;
        if (done) begin mon_busy = 1'b0; n_done++; end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic [7:0] b);
        @(negedge clk); tx_byte = b; tx_go = 1'b1;
        @(negedge clk); tx_go = 1'b0;
    endtask

    task automatic wait_done(output logic e, output logic dp);
        e = 1'bx; dp = 1'bx;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (done) begin e = err; dp = dat_pull; return; end
        end
    endtask

    task automatic wait_high_phase(input int pulses);
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (npulse == pulses && !clk_pull) return;
        end
    endtask

    localparam logic [8:0] VEC [8] = '{
        {1'b1, 8'h00}, {1'b1, 8'hFF}, {1'b0, 8'h01}, {1'b0, 8'h80},
        {1'b1, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h07}, {1'b0, 8'hFE}
    };

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic e, dp;
        logic [7:0] got;
        repeat (3) @(negedge clk);
        chk("R1 clk_pull", clk_pull, 0);
        chk("R1 dat_pull", dat_pull, 0);
        chk("R1 done", done, 0);
        chk("R1 err", err, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // Table walk: frame content, parity, timing
        foreach (VEC[k]) begin
            start(VEC[k][7:0]);
            wait_done(e, dp);
            @(negedge clk);
            chk("R9 err after completion", e, 0);
            chk("R4 pulse count", npulse, 11);
            chk("R4 start bit", bits[0], 0);
            for (int i = 0; i < 8; i++) got[i] = bits[i+1];
            chk("R4 data lsb first", got, VEC[k][7:0]);
            chk("R5 odd parity", bits[9], VEC[k][8]);
            chk("R4 stop bit", bits[10], 1);
            chk("R6 pulse width", lowbad, 0);
            chk("R2 go to first pulse", first_cyc - go_cyc, IDLE_CYC + 1);
            chk("R9 single done", n_done, 1);
        end

        // R3: data low during qualification
        host_dat = 1'b1;
        start(8'h55);
        wait_done(e, dp);
        host_dat = 1'b0;
        @(negedge clk);
        chk("R3 data-busy err", e, 1);
        chk("R3 data-busy no pulse", npulse, 0);

        // R3: clock low late in the window
        start(8'h55);
        repeat (IDLE_CYC - 3) @(negedge clk);
        host_clk = 1'b1;
        wait_done(e, dp);
        host_clk = 1'b0;
        @(negedge clk);
        chk("R3 clock-busy err", e, 1);
        chk("R3 clock-busy no pulse", npulse, 0);

        // R9: error cleared by the next good send
        start(8'h12);
        @(negedge clk);
        chk("R9 err cleared on new send", err, 0);
        wait_done(e, dp);
        chk("R9 err after good send", e, 0);

        // R7: host inhibit after bits 0, 3, 8 (last data), 9 (parity)
        foreach (VEC[k]) begin
            int at;
            if (k > 3) break;
            at = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 8 : 9;
            start(8'hC3);
            wait_high_phase(at + 1);
            host_clk = 1'b1;
            wait_done(e, dp);
            host_clk = 1'b0;
            repeat (HALF_CYC + 2) @(negedge clk);
            chk("R7 abort err", e, 1);
            chk("R7 data released", dp, 0);
            chk("R7 no more pulses", npulse, at + 1);
        end

        // R8: host holds clock after the stop bit
        start(8'h9A);
        wait_high_phase(11);
        host_clk = 1'b1;
        wait_done(e, dp);
        host_clk = 1'b0;
        @(negedge clk);
        chk("R8 no error after stop", e, 0);
        chk("R8 pulse count", npulse, 11);

        // R10: second strobe while busy is ignored
        start(8'h3E);
        repeat (IDLE_CYC + 10) @(negedge clk);
        tx_byte = 8'hC1; tx_go = 1'b1;
        @(negedge clk); tx_go = 1'b0;
        wait_done(e, dp);
        repeat (IDLE_CYC + 4) @(negedge clk);
        for (int i = 0; i < 8; i++) got[i] = bits[i+1];
        chk("R10 original byte sent", got, 8'h3E);
        chk("R10 single done", n_done, 1);
        chk("R10 no second frame", clk_pull, 0);
        chk("R1 idle after frame", dat_pull, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule